// File: doc/BRIEF.md
# Character Dot Address Sequencer

This block steps through the dot list of a character generator memory. A 5-bit dot index forms the low address bits and an 8-bit character index forms the upper bits. Each time a dot fetch completes, the block looks at the returned byte. Its top bit is an active-low marker that flags the last dot of a character.

The marker is carried through two stages, one per fetch. When the marker is low, the dot index returns to zero and the character index advances. The twice-delayed marker drives an inhibit that keeps the beam dark for the first dot of every character. That dot only lets the deflection settle after the jump between characters. When the dot being suppressed also carries the marker, the character holds no visible dots. The block raises a space flag for it and the sequence moves on to the next character.

A load strobe follows every completed fetch by one cycle. It tells the deflection registers to take the position data that was just fetched.

Top module: `charrom_dot_seq`

## Requirements
- R1: A synchronous reset clears both indices to zero and drops the inhibit, the load strobe and the space flag. Both marker stages return to their inactive (high) level, so the first fetch after reset never raises the space flag.
- R2: A fetch whose byte has bit 7 high adds one to the dot index (`rom_addr[4:0]`) and leaves the character index (`rom_addr[12:5]`) unchanged.
- R3: A fetch whose byte has bit 7 low sets the dot index to zero and adds one to the character index, modulo 256.
- R4: In a cycle without a fetch, `rom_addr` does not change, whatever is on `dot_byte`.
- R5: `defl_load` is high for exactly the one cycle after each fetch and low otherwise.
- R6: After a fetch, `first_dot_inh` is high exactly when bit 7 was low in the byte of the fetch before that one. The inhibit changes only at fetches.
- R7: `space_char` pulses for one cycle after a fetch when bit 7 is low in both that fetch's byte and the previous fetch's byte.
- R8: When no marker is seen, the dot index wraps from 31 to 0 and the character index does not change.
- R9: Bits 6 to 0 of `dot_byte` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_end | input | 1 | One-cycle pulse marking the end of a dot fetch |
| dot_byte | input | 8 | Fetched dot byte; bit 7 is the active-low last-dot marker |
| rom_addr | output | 13 | Character memory address: {character index, dot index} |
| first_dot_inh | output | 1 | Keeps the beam dark for the dot just loaded |
| defl_load | output | 1 | Load strobe for the deflection position registers |
| space_char | output | 1 | The suppressed dot also ended its character |

## Verification
The hardest case to reach from the ports is a space character. It needs a low marker on two fetches in a row, which means the delayed marker and the current one must both be low. The stimulus table builds a normal character, ends it, and then sends two characters made only of a marker dot. This drives the inhibit and the space flag together. The table then goes back to a visible dot to confirm that the pipeline releases. A later directed run fills the pipeline with low markers and applies reset. The next fetch after reset must show no space and no inhibit.

// File: rtl/dotseq_pkg.sv
package dotseq_pkg;

    typedef struct packed {
        logic stage1_n;
        logic stage2_n;
        logic load;
        logic space;
    } eoc_pipe_t;

    localparam eoc_pipe_t PIPE_RESET = '{stage1_n: 1'b1, stage2_n: 1'b1, load: 1'b0, space: 1'b0};

endpackage

// File: rtl/dotseq_step_ctr.sv
module dotseq_step_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         clear,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/dotseq_eoc_pipe.sv
module dotseq_eoc_pipe
    import dotseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fetch,
    input  logic eoc_n,
    output logic late_eoc_n,
    output logic load,
    output logic space
);

    eoc_pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.load  = fetch;
        // a first dot that is itself the last one: the character is blank
        pipe_d.space = fetch & ~pipe_q.stage1_n & ~eoc_n;
        if (fetch) begin
            pipe_d.stage1_n = eoc_n;
            pipe_d.stage2_n = pipe_q.stage1_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= PIPE_RESET;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign late_eoc_n = pipe_q.stage2_n;
    assign load       = pipe_q.load;
    assign space      = pipe_q.space;

endmodule

// File: rtl/charrom_dot_seq.sv
module charrom_dot_seq #(
    parameter int DOT_W   = 5,
    parameter int CHAR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int EOC_BIT = DATA_W - 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fetch_end,
    input  logic [DATA_W-1:0]       dot_byte,
    output logic [CHAR_W+DOT_W-1:0] rom_addr,
    output logic                    first_dot_inh,
    output logic                    defl_load,
    output logic                    space_char
);

    logic             eoc_now_n;
    logic             last_dot;
    logic             late_eoc_n;
    logic [DOT_W-1:0] dot_idx;
    logic [CHAR_W-1:0] char_idx;
    logic             unused_data;

    assign eoc_now_n   = dot_byte[EOC_BIT];
    assign last_dot    = fetch_end & ~eoc_now_n;
    assign unused_data = ^dot_byte;

    dotseq_step_ctr #(.W(DOT_W)) u_dot_ctr (
        .clk   (clk),
        .rst   (rst),
        .step  (fetch_end),
        .clear (last_dot),
        .count (dot_idx)
    );

    dotseq_step_ctr #(.W(CHAR_W)) u_char_ctr (
        .clk   (clk),
        .rst   (rst),
        .step  (last_dot),
        .clear (1'b0),
        .count (char_idx)
    );

    dotseq_eoc_pipe u_pipe (
        .clk        (clk),
        .rst        (rst),
        .fetch      (fetch_end),
        .eoc_n      (eoc_now_n),
        .late_eoc_n (late_eoc_n),
        .load       (defl_load),
        .space      (space_char)
    );

    assign rom_addr      = {char_idx, dot_idx};
    assign first_dot_inh = ~late_eoc_n;

endmodule

// File: rtl/charrom_dot_seq_chk.sv
module charrom_dot_seq_chk #(
    parameter int DOT_W  = 5,
    parameter int CHAR_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    fetch_end,
    input logic                    eoc_n,
    input logic [CHAR_W+DOT_W-1:0] rom_addr,
    input logic                    first_dot_inh,
    input logic                    defl_load,
    input logic                    space_char
);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (rom_addr == '0 && !first_dot_inh && !defl_load && !space_char));

    p_dot_step_r2: assert property (@(posedge clk) disable iff (rst)
        (fetch_end && eoc_n) |=>
            (rom_addr[DOT_W-1:0] == DOT_W'($past(rom_addr[DOT_W-1:0]) + 1'b1)) &&
            (rom_addr[CHAR_W+DOT_W-1:DOT_W] == $past(rom_addr[CHAR_W+DOT_W-1:DOT_W])));

    p_char_adv_r3: assert property (@(posedge clk) disable iff (rst)
        (fetch_end && !eoc_n) |=>
            (rom_addr[DOT_W-1:0] == '0) &&
            (rom_addr[CHAR_W+DOT_W-1:DOT_W] == CHAR_W'($past(rom_addr[CHAR_W+DOT_W-1:DOT_W]) + 1'b1)));

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !fetch_end |=> $stable(rom_addr));

    p_load_follow_r5: assert property (@(posedge clk) disable iff (rst)
        fetch_end |=> defl_load);

    p_load_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !fetch_end |=> !defl_load);

    p_inh_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !fetch_end |=> $stable(first_dot_inh));

    p_space_cause_r7: assert property (@(posedge clk) disable iff (rst)
        space_char |-> ($past(fetch_end) && !$past(eoc_n)));

    p_space_inh_r7: assert property (@(posedge clk) disable iff (rst)
        space_char |-> first_dot_inh);

endmodule

bind charrom_dot_seq charrom_dot_seq_chk #(.DOT_W(DOT_W), .CHAR_W(CHAR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .fetch_end     (fetch_end),
    .eoc_n         (dot_byte[EOC_BIT]),
    .rom_addr      (rom_addr),
    .first_dot_inh (first_dot_inh),
    .defl_load     (defl_load),
    .space_char    (space_char)
);

// File: tb/sim_charrom_dot_seq.sv
module sim_charrom_dot_seq;

    localparam int CLK_P  = 10;
    localparam int DOT_W  = 5;
    localparam int CHAR_W = 8;
    localparam int N_VEC  = 10;

    // {byte[22:15], dot[14:10], char[9:2], inhibit[1], space[0]}
    localparam logic [22:0] VEC [N_VEC] = '{
        {8'h80, 5'd1, 8'd0, 1'b0, 1'b0},
        {8'h85, 5'd2, 8'd0, 1'b0, 1'b0},
        {8'h00, 5'd0, 8'd1, 1'b0, 1'b0},
        {8'h9F, 5'd1, 8'd1, 1'b1, 1'b0},
        {8'hC0, 5'd2, 8'd1, 1'b0, 1'b0},
        {8'h7F, 5'd0, 8'd2, 1'b0, 1'b0},
        {8'h00, 5'd0, 8'd3, 1'b1, 1'b1},
        {8'h12, 5'd0, 8'd4, 1'b1, 1'b1},
        {8'h80, 5'd1, 8'd4, 1'b1, 1'b0},
        {8'h81, 5'd2, 8'd4, 1'b0, 1'b0}
    };

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    fetch_end = 1'b0;
    logic [7:0]              dot_byte = 8'h80;
    logic [CHAR_W+DOT_W-1:0] rom_addr;
    logic                    first_dot_inh;
    logic                    defl_load;
    logic                    space_char;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    charrom_dot_seq u0 (
        .clk           (clk),
        .rst           (rst),
        .fetch_end     (fetch_end),
        .dot_byte      (dot_byte),
        .rom_addr      (rom_addr),
        .first_dot_inh (first_dot_inh),
        .defl_load     (defl_load),
        .space_char    (space_char)
    );

    task automatic check_val(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic do_fetch(input logic [7:0] b);
        @(negedge clk);
        fetch_end = 1'b1;
        dot_byte  = b;
        @(negedge clk);
        fetch_end = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_val("R1 addr", int'(rom_addr), 0);
        check_val("R1 inhibit", int'(first_dot_inh), 0);
        check_val("R1 load", int'(defl_load), 0);
        check_val("R1 space", int'(space_char), 0);

        for (int i = 0; i < N_VEC; i++) begin
            logic [CHAR_W+DOT_W-1:0] held;
            do_fetch(VEC[i][22:15]);
            check_val("R2/R3 dot index", int'(rom_addr[DOT_W-1:0]), int'(VEC[i][14:10]));
            check_val("R2/R3 char index", int'(rom_addr[CHAR_W+DOT_W-1:DOT_W]), int'(VEC[i][9:2]));
            check_val("R6 inhibit", int'(first_dot_inh), int'(VEC[i][1]));
            check_val("R7 space", int'(space_char), int'(VEC[i][0]));
            check_val("R5 load after fetch", int'(defl_load), 1);
            held = rom_addr;
            dot_byte = 8'h55;
            @(negedge clk);
            check_val("R5 load idle", int'(defl_load), 0);
            check_val("R4 addr held", int'(rom_addr), int'(held));
            check_val("R7 space one cycle", int'(space_char), 0);
            check_val("R6 inhibit held", int'(first_dot_inh), int'(VEC[i][1]));
        end

        // R8: run the dot index to 31, then past it
        for (int k = 0; k < 29; k++) do_fetch(8'h80);
        check_val("R8 dot at 31", int'(rom_addr[DOT_W-1:0]), 31);
        do_fetch(8'hA3);
        check_val("R8 dot wrap", int'(rom_addr[DOT_W-1:0]), 0);
        check_val("R8 char kept", int'(rom_addr[CHAR_W+DOT_W-1:DOT_W]), 4);
        check_val("R8 no inhibit", int'(first_dot_inh), 0);

        // fill the pipeline with low markers, then reset (R1)
        do_fetch(8'h00);
        do_fetch(8'h00);
        check_val("R7 space before reset", int'(space_char), 1);
        check_val("R3 char before reset", int'(rom_addr[CHAR_W+DOT_W-1:DOT_W]), 6);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_val("R1 addr after reset", int'(rom_addr), 0);
        check_val("R1 inhibit after reset", int'(first_dot_inh), 0);
        do_fetch(8'h00);
        check_val("R1 no space after reset", int'(space_char), 0);
        check_val("R1 no inhibit after reset", int'(first_dot_inh), 0);
        check_val("R3 char after reset", int'(rom_addr[CHAR_W+DOT_W-1:DOT_W]), 1);

        // R9: low bits of the byte are ignored
        do_fetch(8'hFF);
        check_val("R9 dot", int'(rom_addr[DOT_W-1:0]), 1);
        check_val("R9 char", int'(rom_addr[CHAR_W+DOT_W-1:DOT_W]), 1);
        check_val("R9 space", int'(space_char), 0);
        do_fetch(8'h7F);
        check_val("R9 marker only from bit 7", int'(rom_addr), (2 << DOT_W));
        check_val("R9 inhibit", int'(first_dot_inh), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule